// File: doc/BRIEF.md
# Scan-Line Blanking and Vertical Sync Generator

This block is the vertical half of a character-cell style display timing controller. It counts scan lines and raises a vertical blanking output between a programmed first blanked line and a programmed release value. It also drives a vertical sync output between two line numbers supplied on input ports. The horizontal timing is not generated here. A one-clock horizontal sync pulse arrives as an input. The block passes that pulse on through a gated register, and uses it to advance the line counter.

Five control bytes sit behind an index/data port. A write with `cfg_sel` low loads the index. A write with `cfg_sel` high loads the addressed byte. `cfg_rdata` always shows the byte at the current index. The blank start line is ten bits wide and is gathered from three of these bytes. The release compare looks only at the low byte of the line counter, so a blanking window may run across a wrap of that low byte. The mode byte holds a sync enable bit and a bit that halves the line rate.

Top module: `crtc_vblank`

## Requirements
- R1: After reset all five control bytes and the index read as 0x00, the line counter is 0, and `vblank_out`, `vsync_out` and `hsync_out` are low.
- R2: The blank start line is {index 0x09 bit 5, index 0x07 bit 3, index 0x15 bits 7:0}, with bit 9 first. `vblank_out` goes high at the clock edge where the counter moves onto that line. Blanking is never raised on an earlier line.
- R3: `vblank_out` goes low at the clock edge where the counter moves onto a line whose bits 7:0 equal the byte at index 0x16, unless that line is also the start line. Blanking stays high while the low byte of the counter wraps from 0xFF to 0x00.
- R4: Mode byte (index 0x17) bit 7 is the sync enable. While it is 0, `vsync_out` and `hsync_out` are held low. While it is 1, `hsync_out` repeats `hsync_in` one clock later.
- R5: When mode bit 2 is 0, every `hsync_in` pulse advances the counter. When it is 1, only every second pulse does. A write that changes bit 2 resets the phase, so the first pulse after the change does not advance. Without a pulse the counter holds.
- R6: Mode bits 4 and 3 ignore writes and always read back 0.
- R7: On an advance, a counter that is at or above `vtotal` goes to 0. Otherwise it increments by 1.
- R8: With syncs enabled, `vsync_out` goes high on the advance onto line `vs_start`, and goes low on the advance onto line `vs_end`.
- R9: A write to a byte takes effect at the next clock edge. A read returns the stored byte. An index other than 0x07, 0x09, 0x15, 0x16 or 0x17 reads 0x00, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the index/data port |
| cfg_sel | input | 1 | 0 writes the index, 1 writes the addressed byte |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Byte at the current index |
| hsync_in | input | 1 | One-clock horizontal sync pulse |
| vtotal | input | 10 | Last line before the counter wraps |
| vs_start | input | 10 | Line on which vertical sync rises |
| vs_end | input | 10 | Line on which vertical sync falls |
| hsync_out | output | 1 | Gated, registered horizontal sync |
| vsync_out | output | 1 | Vertical sync |
| vblank_out | output | 1 | Vertical blanking |
| line_out | output | 10 | Current scan-line count |

## Verification
The blanking window is tried twice. The first start line uses bit 8 and a release byte whose low-byte match first falls after the counter crosses 0x1FF. This shows whether the release uses the full count or only its low byte. The second start line uses bit 9 alone, which shows whether each high bit comes from its own register. The line counter is driven in both rate modes. A pulse is left pending across a change of the rate bit, which tells a phase reset apart from a free-running divider. Sync outputs are observed with the enable set and cleared, including a walk across `vs_start` while the enable is disabled.

// File: rtl/crtc_vblank.sv
module crtc_vblank #(
  parameter int LW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [7:0]    cfg_wdata,
  output logic [7:0]    cfg_rdata,
  input  logic          hsync_in,
  input  logic [LW-1:0] vtotal,
  input  logic [LW-1:0] vs_start,
  input  logic [LW-1:0] vs_end,
  output logic          hsync_out,
  output logic          vsync_out,
  output logic          vblank_out,
  output logic [LW-1:0] line_out
);
  localparam logic [7:0] IX_OVF  = 8'h07;
  localparam logic [7:0] IX_MSL  = 8'h09;
  localparam logic [7:0] IX_VBS  = 8'h15;
  localparam logic [7:0] IX_VBE  = 8'h16;
  localparam logic [7:0] IX_MODE = 8'h17;
  localparam logic [7:0] MODE_MASK = 8'hE7;

  logic [7:0] idx, r_ovf, r_msl, r_vbs, r_vbe, r_mode;
  logic       div_ph;
  logic [LW-1:0] line_q;

  wire          wr_data  = cfg_we & cfg_sel;
  wire          sync_en  = r_mode[7];
  wire          half     = r_mode[2];
  wire [9:0]    vb_start = {r_msl[5], r_ovf[3], r_vbs};
  wire          tick     = hsync_in & (~half | div_ph);
  wire [LW-1:0] nxt_line = (line_q >= vtotal) ? '0 : line_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0; r_ovf <= '0; r_msl <= '0; r_vbs <= '0; r_vbe <= '0; r_mode <= '0;
    end else if (cfg_we && !cfg_sel) begin
      idx <= cfg_wdata;
    end else if (wr_data) begin
      case (idx)
        IX_OVF:  r_ovf  <= cfg_wdata;
        IX_MSL:  r_msl  <= cfg_wdata;
        IX_VBS:  r_vbs  <= cfg_wdata;
        IX_VBE:  r_vbe  <= cfg_wdata;
        IX_MODE: r_mode <= cfg_wdata & MODE_MASK;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (idx)
      IX_OVF:  cfg_rdata = r_ovf;
      IX_MSL:  cfg_rdata = r_msl;
      IX_VBS:  cfg_rdata = r_vbs;
      IX_VBE:  cfg_rdata = r_vbe;
      IX_MODE: cfg_rdata = r_mode;
      default: cfg_rdata = '0;
    endcase
    if (rst_n && idx == IX_MODE)
      AST_RSVD_ZERO: assert (cfg_rdata[4:3] == 2'b00); // R6
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      div_ph <= 1'b0;
    else if (wr_data && idx == IX_MODE && cfg_wdata[2] != half)
      div_ph <= 1'b0;
    else if (hsync_in && half)
      div_ph <= ~div_ph;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q     <= '0;
      vblank_out <= 1'b0;
    end else if (tick) begin
      line_q <= nxt_line;
      if (nxt_line == LW'(vb_start))
        vblank_out <= 1'b1;
      else if (nxt_line[7:0] == r_vbe)
        vblank_out <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !sync_en) begin
      vsync_out <= 1'b0;
      hsync_out <= 1'b0;
    end else begin
      hsync_out <= hsync_in;
      if (tick) begin
        if (nxt_line == vs_start)
          vsync_out <= 1'b1;
        else if (nxt_line == vs_end)
          vsync_out <= 1'b0;
      end
    end
  end

  assign line_out = line_q;

  AST_SYNC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_en |=> (!vsync_out && !hsync_out)); // R4
  AST_HOLD_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !hsync_in |=> $stable(line_out)); // R5
  AST_BLANK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(line_out) && line_out == LW'($past(vb_start))) |-> vblank_out); // R2
  AST_BLANK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(line_out) && line_out[7:0] == $past(r_vbe) && line_out != LW'($past(vb_start)))
    |-> !vblank_out); // R3
  AST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(line_out) && $past(line_out) >= $past(vtotal)) |-> line_out == '0); // R7
endmodule

// File: tb/crtc_vblank_bench.sv
module crtc_vblank_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_sel = 1'b0, hsync_in = 1'b0;
  logic [7:0] cfg_wdata = '0, cfg_rdata;
  logic [9:0] vtotal = 10'd5, vs_start = 10'd3, vs_end = 10'd6, line_out;
  logic hsync_out, vsync_out, vblank_out, hs_seen;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  crtc_vblank u_crtc_vblank (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .hsync_in(hsync_in),
    .vtotal(vtotal), .vs_start(vs_start), .vs_end(vs_end),
    .hsync_out(hsync_out), .vsync_out(vsync_out), .vblank_out(vblank_out),
    .line_out(line_out)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] ix, input logic [7:0] val);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = ix;
    @(negedge clk); cfg_sel = 1'b1; cfg_wdata = val;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] ix, output logic [7:0] val);
    @(negedge clk); cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = ix;
    @(negedge clk); cfg_we = 1'b0;
    val = cfg_rdata;
  endtask

  task automatic pulse();
    @(negedge clk); hsync_in = 1'b1;
    @(negedge clk); hs_seen = hsync_out; hsync_in = 1'b0;
  endtask

  task automatic goto_line(input int t);
    for (int i = 0; i < 2100 && line_out != 10'(t); i++) pulse();
  endtask

  task automatic t_reset();
    logic [7:0] v;
    check("R1 line", line_out, 0);
    check("R1 vblank", vblank_out, 0);
    check("R1 vsync", vsync_out, 0);
    check("R1 hsync", hsync_out, 0);
    rd(8'h17, v); check("R1 mode", v, 0);
    rd(8'h15, v); check("R1 vbs", v, 0);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    wr(8'h16, 8'h5A); rd(8'h16, v); check("R9 readback", v, 8'h5A);
    wr(8'h30, 8'hFF); rd(8'h30, v); check("R9 unmapped", v, 0);
    rd(8'h16, v); check("R9 unmapped write ignored", v, 8'h5A);
    wr(8'h17, 8'hFF); rd(8'h17, v); check("R6 reserved", v, 8'hE7);
    wr(8'h17, 8'h80);
  endtask

  task automatic t_wrap();
    vtotal = 10'd5;
    goto_line(5); check("R7 reach total", line_out, 5);
    pulse(); check("R7 wrap", line_out, 0);
    goto_line(4); vtotal = 10'd3;
    pulse(); check("R7 above total", line_out, 0);
  endtask

  task automatic t_blank();
    wr(8'h15, 8'h04); wr(8'h07, 8'h08); wr(8'h09, 8'h00); wr(8'h16, 8'h02);
    vtotal = 10'd600;
    goto_line(600); pulse(); goto_line(259);
    check("R2 before start", vblank_out, 0);
    pulse(); check("R2 start 0x104", vblank_out, 1);
    goto_line(513); check("R3 held across low wrap", vblank_out, 1);
    pulse(); check("R3 release 0x202", vblank_out, 0);
    wr(8'h15, 8'h00); wr(8'h07, 8'h00); wr(8'h09, 8'h20); wr(8'h16, 8'h05);
    goto_line(600); pulse(); goto_line(511);
    check("R2 bit9 before", vblank_out, 0);
    pulse(); check("R2 start 0x200", vblank_out, 1);
    goto_line(516); check("R3 hold", vblank_out, 1);
    pulse(); check("R3 release 0x205", vblank_out, 0);
  endtask

  task automatic t_sync();
    vtotal = 10'd20;
    goto_line(2); check("R8 before start", vsync_out, 0);
    pulse(); check("R8 start", vsync_out, 1);
    check("R4 hsync passes", hs_seen, 1);
    goto_line(5); check("R8 hold", vsync_out, 1);
    pulse(); check("R8 end", vsync_out, 0);
    goto_line(2); check("R8 before start again", vsync_out, 0);
    wr(8'h17, 8'h00);
    pulse(); check("R4 vsync gated", vsync_out, 0);
    check("R4 hsync gated", hs_seen, 0);
    wr(8'h17, 8'h80);
  endtask

  task automatic t_div();
    int l;
    goto_line(1);
    wr(8'h17, 8'h84);
    l = line_out;
    pulse(); check("R5 half first", line_out, l);
    pulse(); check("R5 half second", line_out, l + 1);
    pulse(); check("R5 half pending", line_out, l + 1);
    wr(8'h17, 8'h80); wr(8'h17, 8'h84);
    pulse(); check("R5 phase reset", line_out, l + 1);
    pulse(); check("R5 advance after reset", line_out, l + 2);
    repeat (3) @(negedge clk);
    check("R5 hold without pulse", line_out, l + 2);
    wr(8'h17, 8'h80);
    pulse(); check("R5 full rate", line_out, l + 3);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_wrap();
    t_blank();
    t_sync();
    t_div();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule